// File: doc/BRIEF.md
# I2C Slave Write Receiver

This block is the receive half of an I2C target. It watches the two bus lines through a synchronizer and finds START, repeated START and STOP. After a START it compares the address phase with an own address held in a register, using either the 7-bit form or the two-byte 10-bit form. When the address matches on a write transfer, it acknowledges and then shifts each following data byte into a receive register. The bus is released open-drain style: the block only ever asks for a line to be pulled low, through `sda_oe` and `scl_oe`.

Software uses a small word-addressed register port. It can set up the mode and the own address, and it can arm a one-shot NACK for the next byte, which is how the last byte of a transfer is refused. It reads the received byte and clears event flags by writing ones. While a received byte sits unread, the block keeps SCL low, so the sender cannot overrun it.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset both line pulls are released, `irq` is low, every status and control bit reads 0, and the own address reads 0.
- R2: In 7-bit mode, a first byte equal to {own_addr[6:0], 0} is answered with ACK (SDA pulled low during the ninth clock). The start flag and the busy bit are then set.
- R3: In 10-bit mode, a first byte of 1,1,1,1,0, own_addr[9:8], 0 is answered with ACK but sets no flag. A second byte equal to own_addr[7:0] is then acknowledged, and the start flag and busy bit are set. A wrong second byte gets NACK.
- R4: A mismatching address, a read bit of 1, or master-select set all give NACK. The block then ignores every byte until the next START or repeated START, and no flag changes.
- R5: Each data byte of an addressed write is acknowledged and appears at the receive data offset. It sets both the byte-end flag and the buffer-full flag.
- R6: After an acknowledged data byte, SCL is held low until the receive data offset is read. Reading that offset clears buffer-full and releases SCL.
- R7: Writing 1 to the arm-NACK control bit makes the next data byte be answered with NACK. That byte is still stored, SCL is not held after it, and the arm bit reads 0 once the NACK has been sent.
- R8: A STOP or a (repeated) START clears the arm-NACK bit.
- R9: A STOP seen while busy sets the stop flag and clears busy. A STOP while not addressed changes nothing.
- R10: A repeated START restarts address matching. A new match sets the start flag again.
- R11: Writing 1 to a flag bit at the status offset clears it, and writing 0 leaves it alone. `irq` is high while any flag is set.
- R12: Register map, word offsets: 0 control {bit0 master-select, bit1 ten-bit mode, bit2 arm-NACK}; 1 own address [9:0]; 2 status {bit0 start, bit1 stop, bit2 byte-end, bit3 buffer-full, bit8 busy (read only)}; 3 receive data [7:0] (read only). Buffer-full is cleared only by reading offset 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled SCL bus level |
| sda_in | input | 1 | Sampled SDA bus level |
| scl_oe | output | 1 | Pull SCL low (clock hold) |
| sda_oe | output | 1 | Pull SDA low (acknowledge) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on receive data) |
| reg_addr | input | REG_AW | Register word offset |
| reg_wdata | input | REG_DW | Register write data |
| reg_rdata | output | REG_DW | Register read data, combinational from reg_addr |
| irq | output | 1 | OR of the event flags |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer, a 2-bit register offset and 16-bit register words. With these values the detection path is about four clocks long. That is well inside the 20-clock bus phases the bench master uses, so every acknowledge slot, hold window and bus condition can be observed from the bus side. The 16-bit word exposes the 10-bit own address and the busy bit, so both address modes and the busy transitions can be checked at the register port.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned OWN_W  = 10;

   // register word offsets
   localparam int unsigned OFS_CTRL = 0;
   localparam int unsigned OFS_OWN  = 1;
   localparam int unsigned OFS_STAT = 2;
   localparam int unsigned OFS_RXD  = 3;

   // status bit positions
   localparam int unsigned SB_START = 0;
   localparam int unsigned SB_STOP  = 1;
   localparam int unsigned SB_BEND  = 2;
   localparam int unsigned SB_RXF   = 3;
   localparam int unsigned SB_BUSY  = 8;

   // fixed high part of the first byte of a ten-bit address
   localparam logic [4:0] TEN_PREFIX = 5'b11110;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADR1,
      PH_ADR2,
      PH_DATA,
      PH_SKIP
   } srx_phase_e;

endpackage

// File: rtl/i2c_srx_cond.sv
module i2c_srx_cond #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_d;
   logic              sda_d;
   logic              scl_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("i2c_srx_cond: STAGES must be at least 2");
      end
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe <= {scl_pipe[0], scl_in};
               sda_pipe <= {sda_pipe[0], sda_in};
            end
         end
      end else begin : g_deep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
               sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_pipe[STAGES-1];
         sda_d <= sda_pipe[STAGES-1];
      end
   end

   assign scl_q     = scl_pipe[STAGES-1];
   assign sda_q     = sda_pipe[STAGES-1];
   assign scl_rise  = !scl_d && scl_q;
   assign scl_fall  = scl_d && !scl_q;
   // SDA edge while SCL stays high marks a bus condition
   assign start_det = scl_d && scl_q && sda_d && !sda_q;
   assign stop_det  = scl_d && scl_q && !sda_d && sda_q;

endmodule

// File: rtl/i2c_srx_engine.sv
module i2c_srx_engine
   import i2c_srx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_q,
   input  logic              mst_sel,
   input  logic              addr10,
   input  logic [OWN_W-1:0]  own_addr,
   input  logic              nack_arm,
   input  logic              rx_full,
   output logic              sda_drive,
   output logic              scl_hold,
   output logic              addr_match,
   output logic              byte_done,
   output logic              nack_sent,
   output logic [BYTE_W-1:0] byte_data
);

   localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

   srx_phase_e        phase;
   srx_phase_e        phase_nxt;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic              ack_ph;
   logic              ack_q;
   logic              hold_q;
   logic              accept;
   logic              final_match;
   logic              active;

   assign active = (phase == PH_ADR1) || (phase == PH_ADR2) || (phase == PH_DATA);

   // acknowledge decision for the byte that just completed
   always_comb begin
      accept      = 1'b0;
      final_match = 1'b0;
      case (phase)
         PH_ADR1: begin
            if (mst_sel) begin
               accept = 1'b0;
            end else if (addr10) begin
               accept = (shreg[7:3] == TEN_PREFIX) && (shreg[2:1] == own_addr[9:8]) && !shreg[0];
            end else begin
               accept      = (shreg[7:1] == own_addr[6:0]) && !shreg[0];
               final_match = accept;
            end
         end
         PH_ADR2: begin
            accept      = (shreg == own_addr[7:0]);
            final_match = accept;
         end
         PH_DATA: accept = !nack_arm;
         default: accept = 1'b0;
      endcase
   end

   // phase after the acknowledge clock, using the stored decision
   always_comb begin
      phase_nxt = PH_SKIP;
      case (phase)
         PH_ADR1: phase_nxt = ack_q ? (addr10 ? PH_ADR2 : PH_DATA) : PH_SKIP;
         PH_ADR2: phase_nxt = ack_q ? PH_DATA : PH_SKIP;
         PH_DATA: phase_nxt = ack_q ? PH_DATA : PH_SKIP;
         default: phase_nxt = phase;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         bit_cnt    <= '0;
         shreg      <= '0;
         ack_ph     <= 1'b0;
         ack_q      <= 1'b0;
         hold_q     <= 1'b0;
         addr_match <= 1'b0;
         byte_done  <= 1'b0;
         nack_sent  <= 1'b0;
      end else begin
         addr_match <= 1'b0;
         byte_done  <= 1'b0;
         nack_sent  <= 1'b0;
         if (start_det || stop_det) begin
            phase   <= start_det ? PH_ADR1 : PH_IDLE;
            bit_cnt <= '0;
            ack_ph  <= 1'b0;
            ack_q   <= 1'b0;
            hold_q  <= 1'b0;
         end else begin
            if (hold_q && !rx_full) begin
               hold_q <= 1'b0;
            end
            if (active) begin
               if (scl_rise && !ack_ph && (bit_cnt < FULL_CNT)) begin
                  shreg   <= {shreg[BYTE_W-2:0], sda_q};
                  bit_cnt <= bit_cnt + 1'b1;
               end
               if (scl_fall) begin
                  if (!ack_ph && (bit_cnt == FULL_CNT)) begin
                     ack_ph     <= 1'b1;
                     ack_q      <= accept;
                     byte_done  <= (phase == PH_DATA);
                     addr_match <= final_match;
                  end else if (ack_ph) begin
                     ack_ph  <= 1'b0;
                     ack_q   <= 1'b0;
                     bit_cnt <= '0;
                     phase   <= phase_nxt;
                     if (phase == PH_DATA) begin
                        if (ack_q) begin
                           hold_q <= 1'b1;
                        end else begin
                           nack_sent <= 1'b1;
                        end
                     end
                  end
               end
            end
         end
      end
   end

   assign sda_drive = ack_ph && ack_q;
   assign scl_hold  = hold_q;
   assign byte_data = shreg;

endmodule

// File: rtl/i2c_srx_regs.sv
module i2c_srx_regs
   import i2c_srx_pkg::*;
#(
   parameter int unsigned REG_AW = 2,
   parameter int unsigned REG_DW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   output logic              irq,
   input  logic              addr_match,
   input  logic              byte_done,
   input  logic [BYTE_W-1:0] byte_data,
   input  logic              nack_sent,
   input  logic              start_det,
   input  logic              stop_det,
   output logic              mst_sel,
   output logic              addr10,
   output logic [OWN_W-1:0]  own_addr,
   output logic              nack_arm,
   output logic              rx_full
);

   localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(OFS_CTRL);
   localparam logic [REG_AW-1:0] A_OWN  = REG_AW'(OFS_OWN);
   localparam logic [REG_AW-1:0] A_STAT = REG_AW'(OFS_STAT);
   localparam logic [REG_AW-1:0] A_RXD  = REG_AW'(OFS_RXD);

   logic              fl_start;
   logic              fl_stop;
   logic              fl_bend;
   logic              busy;
   logic [BYTE_W-1:0] rxd;
   logic              wr_ctrl;
   logic              wr_stat;
   logic              rd_rxd;
   logic              unused_wbits;

   assign wr_ctrl      = reg_wr && (reg_addr == A_CTRL);
   assign wr_stat      = reg_wr && (reg_addr == A_STAT);
   assign rd_rxd       = reg_rd && (reg_addr == A_RXD);
   assign unused_wbits = ^reg_wdata[REG_DW-1:OWN_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mst_sel  <= 1'b0;
         addr10   <= 1'b0;
         nack_arm <= 1'b0;
         own_addr <= '0;
      end else begin
         if (nack_sent || start_det || stop_det) begin
            nack_arm <= 1'b0;
         end
         if (wr_ctrl) begin
            mst_sel  <= reg_wdata[0];
            addr10   <= reg_wdata[1];
            nack_arm <= reg_wdata[2];
         end
         if (reg_wr && (reg_addr == A_OWN)) begin
            own_addr <= reg_wdata[OWN_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fl_start <= 1'b0;
         fl_stop  <= 1'b0;
         fl_bend  <= 1'b0;
         rx_full  <= 1'b0;
         busy     <= 1'b0;
         rxd      <= '0;
      end else begin
         if (wr_stat) begin
            if (reg_wdata[SB_START]) fl_start <= 1'b0;
            if (reg_wdata[SB_STOP])  fl_stop  <= 1'b0;
            if (reg_wdata[SB_BEND])  fl_bend  <= 1'b0;
         end
         if (rd_rxd) begin
            rx_full <= 1'b0;
         end
         if (addr_match) begin
            fl_start <= 1'b1;
            busy     <= 1'b1;
         end
         if (stop_det && busy) begin
            fl_stop <= 1'b1;
            busy    <= 1'b0;
         end
         if (byte_done) begin
            rxd     <= byte_data;
            fl_bend <= 1'b1;
            rx_full <= 1'b1;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_CTRL) begin
         reg_rdata[2:0] = {nack_arm, addr10, mst_sel};
      end else if (reg_addr == A_OWN) begin
         reg_rdata[OWN_W-1:0] = own_addr;
      end else if (reg_addr == A_STAT) begin
         reg_rdata[SB_START] = fl_start;
         reg_rdata[SB_STOP]  = fl_stop;
         reg_rdata[SB_BEND]  = fl_bend;
         reg_rdata[SB_RXF]   = rx_full;
         reg_rdata[SB_BUSY]  = busy;
      end else begin
         reg_rdata[BYTE_W-1:0] = rxd;
      end
   end

   assign irq = fl_start | fl_stop | fl_bend | rx_full;

endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
   import i2c_srx_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned REG_AW      = 2,
   parameter int unsigned REG_DW      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_oe,
   output logic              sda_oe,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   output logic              irq
);

   generate
      if (REG_DW < SB_BUSY + 2) begin : g_bad_dw
         $error("i2c_slave_rx: REG_DW too narrow for the own address and busy bit");
      end
      if (REG_AW < 2) begin : g_bad_aw
         $error("i2c_slave_rx: REG_AW must cover four register offsets");
      end
   endgenerate

   logic              sda_q;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic              mst_sel;
   logic              addr10;
   logic [OWN_W-1:0]  own_addr;
   logic              nack_arm;
   logic              rx_full;
   logic              addr_match;
   logic              byte_done;
   logic              nack_sent;
   logic [BYTE_W-1:0] byte_data;

   i2c_srx_cond #(.STAGES(SYNC_STAGES)) u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .sda_q     (sda_q),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_srx_engine u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_det  (start_det),
      .stop_det   (stop_det),
      .sda_q      (sda_q),
      .mst_sel    (mst_sel),
      .addr10     (addr10),
      .own_addr   (own_addr),
      .nack_arm   (nack_arm),
      .rx_full    (rx_full),
      .sda_drive  (sda_oe),
      .scl_hold   (scl_oe),
      .addr_match (addr_match),
      .byte_done  (byte_done),
      .nack_sent  (nack_sent),
      .byte_data  (byte_data)
   );

   i2c_srx_regs #(.REG_AW(REG_AW), .REG_DW(REG_DW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .irq        (irq),
      .addr_match (addr_match),
      .byte_done  (byte_done),
      .byte_data  (byte_data),
      .nack_sent  (nack_sent),
      .start_det  (start_det),
      .stop_det   (stop_det),
      .mst_sel    (mst_sel),
      .addr10     (addr10),
      .own_addr   (own_addr),
      .nack_arm   (nack_arm),
      .rx_full    (rx_full)
   );

endmodule

// File: rtl/i2c_slave_rx_chk.sv
module i2c_slave_rx_chk #(
   parameter int unsigned REG_AW = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_oe,
   input logic              sda_oe,
   input logic              rx_full,
   input logic              nack_arm,
   input logic              mst_sel,
   input logic              addr_match,
   input logic              byte_done,
   input logic              nack_sent,
   input logic              start_det,
   input logic              stop_det,
   input logic              reg_wr,
   input logic [REG_AW-1:0] reg_addr
);

   logic ctrl_wr;
   assign ctrl_wr = reg_wr && (reg_addr == '0);

   // R5: a stored data byte marks the buffer full
   a_r5_byte_fills_buffer: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> rx_full);

   // R6: the clock hold ends once the buffer is emptied
   a_r6_release_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_full) |=> !scl_oe);

   // R6: SDA is never pulled while SCL is held
   a_r6_no_ack_during_hold: assert property (@(posedge clk) disable iff (!rst_n)
      scl_oe |-> !sda_oe);

   // R7: a refused byte does not hold the clock
   a_r7_nack_byte_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
      nack_sent |=> !scl_oe);

   // R7: the arm bit drops after its NACK went out
   a_r7_arm_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (nack_sent && !ctrl_wr) |=> !nack_arm);

   // R8: bus conditions disarm the NACK
   a_r8_cond_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      ((start_det || stop_det) && !ctrl_wr) |=> !nack_arm);

   // R4: with master-select set no address is accepted
   a_r4_master_no_match: assert property (@(posedge clk) disable iff (!rst_n)
      addr_match |-> !$past(mst_sel));

endmodule

bind i2c_slave_rx i2c_slave_rx_chk #(.REG_AW(REG_AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_oe     (scl_oe),
   .sda_oe     (sda_oe),
   .rx_full    (rx_full),
   .nack_arm   (nack_arm),
   .mst_sel    (mst_sel),
   .addr_match (addr_match),
   .byte_done  (byte_done),
   .nack_sent  (nack_sent),
   .start_det  (start_det),
   .stop_det   (stop_det),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr)
);

// File: tb/tb_i2c_slave_rx.sv
module tb_i2c_slave_rx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_sda = 1'b1;
   logic        scl_oe;
   logic        sda_oe;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        irq;
   logic        scl_bus;
   logic        sda_bus;

   assign scl_bus = m_scl & ~scl_oe;
   assign sda_bus = m_sda & ~sda_oe;

   always #5 clk = ~clk;

   i2c_slave_rx dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_bus),
      .sda_in    (sda_bus),
      .scl_oe    (scl_oe),
      .sda_oe    (sda_oe),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );

   int n_chk = 0;
   int n_fail = 0;
   int mon_err = 0;
   bit done = 0;
   bit ack_win = 0;

   // behavioural model: phase 0 idle, 1 first address, 2 second address, 3 data, 4 skip
   int m_st = 0;
   bit m_mst = 0, m_ten = 0, m_nack = 0;
   int m_own = 0;
   bit m_start = 0, m_stop = 0, m_bend = 0, m_rxf = 0, m_busy = 0;
   int m_rxd = 0;

   function automatic int stat_model();
      return (int'(m_busy) << 8) | (int'(m_rxf) << 3) | (int'(m_bend) << 2) |
             (int'(m_stop) << 1) | int'(m_start);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = 16'(d);
      @(negedge clk);
      reg_wr = 1'b0;
      if (a == 0) begin m_mst = d[0]; m_ten = d[1]; m_nack = d[2]; end
      if (a == 1) m_own = d & 32'h3ff;
      if (a == 2) begin
         if (d[0]) m_start = 0;
         if (d[1]) m_stop = 0;
         if (d[2]) m_bend = 0;
      end
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = 2'(a);
      #1 d = int'(reg_rdata);
      @(negedge clk);
      reg_rd = 1'b0;
      if (a == 3) m_rxf = 0;
   endtask

   task automatic check_stat(input string req);
      int v;
      rd(2, v);
      check(req, v, stat_model());
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wait_n(10);
      while (scl_oe) @(negedge clk);
      m_scl = 1'b1; wait_n(10);
      m_sda = 1'b0; wait_n(10);
      m_scl = 1'b0; wait_n(10);
      m_nack = 0; m_st = 1;
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wait_n(10);
      while (scl_oe) @(negedge clk);
      m_scl = 1'b1; wait_n(10);
      m_sda = 1'b1; wait_n(20);
      if (m_busy) begin m_stop = 1; m_busy = 0; end
      m_nack = 0; m_st = 0;
   endtask

   task automatic send_byte(input int b, input string req);
      bit exp_ack, act_ack;
      exp_ack = 0;
      case (m_st)
         1: begin
            if (m_mst) exp_ack = 0;
            else if (m_ten) exp_ack = (b[7:3] == 5'b11110) && (b[2:1] == m_own[9:8]) && !b[0];
            else exp_ack = (b[7:1] == m_own[6:0]) && !b[0];
            if (exp_ack && !m_ten) begin m_start = 1; m_busy = 1; end
            m_st = exp_ack ? (m_ten ? 2 : 3) : 4;
         end
         2: begin
            exp_ack = (b[7:0] == m_own[7:0]);
            if (exp_ack) begin m_start = 1; m_busy = 1; end
            m_st = exp_ack ? 3 : 4;
         end
         3: begin
            exp_ack = !m_nack;
            m_rxd = b & 32'hff; m_bend = 1; m_rxf = 1;
            if (!exp_ack) begin m_nack = 0; m_st = 4; end
         end
         default: exp_ack = 0;
      endcase
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; wait_n(10);
         while (scl_oe) @(negedge clk);
         m_scl = 1'b1; wait_n(20);
         if (i == 0) ack_win = 1;
         m_scl = 1'b0; wait_n(10);
      end
      m_sda = 1'b1; wait_n(10);
      m_scl = 1'b1; wait_n(10);
      act_ack = !sda_bus;
      wait_n(10);
      m_scl = 1'b0; wait_n(10);
      ack_win = 0;
      check(req, int'(act_ack), int'(exp_ack));
   endtask

   // SDA may only be pulled inside an acknowledge slot
   always @(negedge clk) begin
      if (rst_n && sda_oe && !ack_win) mon_err++;
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int v;
      wait_n(4);
      rst_n = 1'b1;
      wait_n(4);

      // R1 reset state
      check("R1 sda_oe", int'(sda_oe), 0);
      check("R1 scl_oe", int'(scl_oe), 0);
      check("R1 irq", int'(irq), 0);
      check_stat("R1 status");
      rd(0, v); check("R1 control", v, 0);
      rd(1, v); check("R1 own address", v, 0);

      // R2 / R12 seven-bit match
      wr(1, 'h2A); wr(0, 0);
      rd(1, v); check("R12 own address", v, 'h2A);
      bus_start();
      send_byte('h54, "R2 address ack");
      check_stat("R2 start+busy");
      check("R11 irq on flag", int'(irq), 1);
      wr(2, 0); check_stat("R11 write zero keeps");
      wr(2, 1); check_stat("R11 write one clears");

      // R5 / R6 data byte and clock hold
      send_byte('hA5, "R5 data ack");
      check("R6 hold active", int'(scl_oe), 1);
      check_stat("R5 flags");
      rd(3, v); check("R5 rx data", v, 'hA5);
      wait_n(4);
      check("R6 hold released", int'(scl_oe), 0);
      check_stat("R6 full cleared");

      // R7 armed NACK
      wr(0, 4);
      rd(0, v); check("R7 arm reads back", v, 4);
      send_byte('h3C, "R7 nack on data");
      check("R7 no hold after nack", int'(scl_oe), 0);
      rd(0, v); check("R7 arm auto cleared", v, 0);
      rd(3, v); check("R7 byte stored", v, 'h3C);

      // R9 stop
      bus_stop();
      check_stat("R9 stop flag");
      wr(2, 'hF); check_stat("R11 clear all");
      check("R11 irq low", int'(irq), 0);

      // R4 wrong address then data ignored
      bus_start();
      send_byte('h56, "R4 wrong address");
      send_byte('hFF, "R4 byte ignored");
      bus_stop();
      check_stat("R4 no flags");

      // R4 read direction
      bus_start();
      send_byte('h55, "R4 read bit");
      bus_stop();
      check_stat("R4 no flags read");

      // R8 / R10 repeated start
      bus_start();
      send_byte('h54, "R10 first match");
      send_byte('h11, "R5 data ack");
      rd(3, v); check("R5 rx data", v, 'h11);
      wr(2, 'hF);
      wr(0, 4);
      bus_start();
      rd(0, v); check("R8 restart disarms", v, 0);
      check_stat("R10 no flag before address");
      send_byte('h54, "R10 rematch");
      check_stat("R10 start again");
      send_byte('h22, "R5 data after restart");
      rd(3, v); check("R5 rx data", v, 'h22);
      wr(0, 4);
      bus_stop();
      rd(0, v); check("R8 stop disarms", v, 0);
      check_stat("R9 stop after restart");
      wr(2, 'hF);

      // R3 ten-bit address
      wr(0, 2); wr(1, 'h2B5);
      bus_start();
      send_byte('hF4, "R3 first byte ack");
      check_stat("R3 no flag after first byte");
      send_byte('hB5, "R3 second byte ack");
      check_stat("R3 start+busy");
      send_byte('h5A, "R5 data ten-bit");
      rd(3, v); check("R5 rx data ten-bit", v, 'h5A);
      bus_stop();
      wr(2, 'hF);
      check_stat("R9 cleared");

      bus_start();
      send_byte('hF4, "R3 first byte ack");
      send_byte('hB4, "R3 wrong low byte");
      bus_stop();
      check_stat("R3 no flags on miss");

      // R4 master-select
      wr(0, 1); wr(1, 'h2A);
      bus_start();
      send_byte('h54, "R4 master select");
      bus_stop();
      check_stat("R4 no flags master");

      check("R2 sda pulled only in ack slots", mon_err, 0);
      finish_run();
   end

endmodule